// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block is the slave-side identification logic for a device that signals an event on a shared, active-low interrupt wire. Several devices may share that wire. The host finds out which device raised it by broadcasting the alert response read on the I2C bus. A device that has an alert pending acknowledges that broadcast. It then transmits its own 7-bit bus address, most significant bit first, followed by one live status bit. Open-drain arbitration on SDA lets the numerically lowest responder win. The winner releases its interrupt wire. A loser keeps the interrupt wire asserted, so the host repeats the broadcast until the shared wire goes inactive.

SCL and SDA pass through a synchroniser, and START, STOP and SCL edges are then derived from the synchronised lines. A state machine follows the transfer. Its states are IDLE, ADDR (shifting in the address byte), ADDR_END (eight bits received, waiting for SCL low), ADDR_ACK (pulling SDA low for the acknowledge clock), SEND (shifting out the response byte), MACK (SDA released during the host's acknowledge clock), LOST (arbitration lost, waiting for the bus) and SKIP (byte not for this block).

The transitions are as follows. IDLE goes to ADDR on START. ADDR goes to ADDR_END on the eighth SCL rise. ADDR_END goes to ADDR_ACK on the next SCL fall if the byte matches and the block is armed; otherwise it goes to SKIP. ADDR_ACK goes to SEND on SCL fall. SEND goes to LOST when a released bit reads back low at SCL rise, and to MACK on the SCL fall after the eighth bit. MACK goes to IDLE on SCL fall. From any state, START leads to ADDR and STOP leads to IDLE. Both SDA and the interrupt wire are modelled as active-high pull-down enables.

Top module: `smb_alert_responder`

## Requirements
- R1: After reset, both pull-down enables `sda_pd` and `int_pd` are 0.
- R2: With `latch_mode`=1, a rising edge on `irq_pend` sets `int_pd`, and `int_pd` then holds until a won response. With `latch_mode`=0, `int_pd` follows `irq_pend` one clock later.
- R3: With `latch_mode`=1 and `int_pd`=1, the address byte 0x19 (7-bit address 0001100 followed by read bit 1, first bit on the bus = byte bit 7) is acknowledged: `sda_pd`=1 while SCL is low in the ninth clock.
- R4: With `latch_mode`=0, the byte 0x19 is not acknowledged and `sda_pd` stays 0.
- R5: With `int_pd`=0, the byte 0x19 is not acknowledged.
- R6: No other address byte is acknowledged (for example 0x18 or 0x90), and `sda_pd` stays 0 while the address byte is received.
- R7: After the acknowledge, the block sends the byte {OWN_ADDR[6:0], flag_hi}, bit 7 first. `flag_hi` is sampled as the acknowledge clock ends. A 0 bit gives `sda_pd`=1 and a 1 bit gives `sda_pd`=0.
- R8: If SDA reads low at an SCL rise while the block is sending a 1, the block releases SDA for the rest of the transfer and `int_pd` stays 1.
- R9: If all eight bits are sent without loss, `int_pd` falls after the eighth bit. SDA is released during the host's acknowledge clock, and a later broadcast is not acknowledged.
- R10: A START aborts any transfer (SDA released, `int_pd` unchanged) and restarts address reception. A STOP returns the block to idle.
- R11: `sda_pd` only asserts while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| latch_mode | input | 1 | 1 = latched interrupt mode (responding armed), 0 = transparent |
| irq_pend | input | 1 | Interrupt-pending level from the comparator |
| flag_hi | input | 1 | High-threshold status bit, returned as the eighth bit |
| sda_pd | output | 1 | SDA pull-down enable (1 drives the line low) |
| int_pd | output | 1 | Interrupt pull-down enable (1 = interrupt active) |

## Verification
The bench runs rival responders that lose to this block, beat it at the first bit, and beat it late at the sixth bit. A design that compares arbitration at the wrong bit, or keeps driving after a loss, corrupts the byte that is read back or clears the interrupt wrongly. It also broadcasts in transparent mode, with no alert pending, and with near-miss address bytes; a weak address or arming check would acknowledge one of these. A repeated START right after the acknowledge, and a STOP partway through an address, test that aborting leaves the interrupt set and that the next broadcast is still decoded from bit 7. The status bit is exercised both as 0 and as 1, to catch a response that fixes the LSB as a read bit.

// File: rtl/smb_alert_pkg.sv
package smb_alert_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_END,
        ST_ADDR_ACK,
        ST_SEND,
        ST_MACK,
        ST_LOST,
        ST_SKIP
    } resp_state_e;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '1;
        else        chain[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= '1;
            else        chain[g] <= chain[g-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_ev,
    output logic stop_ev,
    output logic scl_rise,
    output logic scl_fall
);

    logic scl_prev;
    logic sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    assign start_ev = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_ev  = scl_s & scl_prev & ~sda_prev & sda_s;
    assign scl_rise = scl_s & ~scl_prev;
    assign scl_fall = ~scl_s & scl_prev;

endmodule

// File: rtl/smb_alert_latch.sv
module smb_alert_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic latch_mode,
    input  logic irq_pend,
    input  logic win_clr,
    output logic int_act
);

    logic irq_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_prev <= 1'b0;
            int_act  <= 1'b0;
        end else begin
            irq_prev <= irq_pend;
            if (!latch_mode)
                int_act <= irq_pend;
            else if (irq_pend && !irq_prev)
                int_act <= 1'b1;
            else if (win_clr)
                int_act <= 1'b0;
        end
    end

endmodule

// File: rtl/smb_alert_responder.sv
module smb_alert_responder
    import smb_alert_pkg::*;
#(
    parameter int                ADDR_W      = 7,
    parameter logic [ADDR_W-1:0] OWN_ADDR    = 7'h4A,
    parameter logic [ADDR_W-1:0] ALERT_ADDR  = 7'h0C,
    parameter int                SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic latch_mode,
    input  logic irq_pend,
    input  logic flag_hi,
    output logic sda_pd,
    output logic int_pd
);

    localparam int                   DATA_BITS = ADDR_W + 1;
    localparam int                   BIT_W     = $clog2(DATA_BITS);
    localparam logic [BIT_W-1:0]     LAST_BIT  = BIT_W'(DATA_BITS - 1);
    localparam logic [DATA_BITS-1:0] MATCH_BYTE = {ALERT_ADDR, 1'b1};

    logic scl_s, sda_s;
    logic start_ev, stop_ev, scl_rise, scl_fall;
    logic win_clr, int_act;

    resp_state_e          state_q, state_d;
    logic [BIT_W-1:0]     bit_q, bit_d;
    logic [DATA_BITS-1:0] shift_q, shift_d;
    logic [DATA_BITS-1:0] tx_q, tx_d;
    logic                 sda_pd_q;

    smb_line_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (2)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     ({scl_s, sda_s})
    );

    smb_bus_events u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    smb_alert_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .latch_mode (latch_mode),
        .irq_pend   (irq_pend),
        .win_clr    (win_clr),
        .int_act    (int_act)
    );

    // Next-state and datapath decisions
    always_comb begin
        state_d = state_q;
        bit_d   = bit_q;
        shift_d = shift_q;
        tx_d    = tx_q;
        win_clr = 1'b0;
        if (start_ev) begin
            state_d = ST_ADDR;
            bit_d   = '0;
        end else if (stop_ev) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (scl_rise) begin
                        shift_d = {shift_q[DATA_BITS-2:0], sda_s};
                        if (bit_q == LAST_BIT) state_d = ST_ADDR_END;
                        else                   bit_d   = bit_q + 1'b1;
                    end
                end
                ST_ADDR_END: begin
                    if (scl_fall) begin
                        if (shift_q == MATCH_BYTE && latch_mode && int_act)
                            state_d = ST_ADDR_ACK;
                        else
                            state_d = ST_SKIP;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        tx_d    = {OWN_ADDR, flag_hi};
                        bit_d   = '0;
                        state_d = ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (scl_rise && tx_q[DATA_BITS-1] && !sda_s) begin
                        state_d = ST_LOST;
                    end else if (scl_fall) begin
                        if (bit_q == LAST_BIT) begin
                            state_d = ST_MACK;
                            win_clr = 1'b1;
                        end else begin
                            bit_d = bit_q + 1'b1;
                            tx_d  = {tx_q[DATA_BITS-2:0], 1'b0};
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_fall) state_d = ST_IDLE;
                end
                ST_LOST: ;
                ST_SKIP: ;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            shift_q <= '0;
            tx_q    <= '0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
            shift_q <= shift_d;
            tx_q    <= tx_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sda_pd_q <= 1'b0;
        else        sda_pd_q <= (state_d == ST_ADDR_ACK) ||
                                (state_d == ST_SEND && !tx_d[DATA_BITS-1]);
    end

    assign sda_pd = sda_pd_q;
    assign int_pd = int_act;

endmodule

// File: rtl/smb_alert_chk.sv
module smb_alert_chk
    import smb_alert_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        scl_s,
    input logic        stop_ev,
    input logic        latch_mode,
    input logic        int_pd,
    input logic        sda_pd,
    input resp_state_e state
);

    AST_ACK_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK && $past(state) != ST_ADDR_ACK)
            |-> ($past(latch_mode) && $past(int_pd)));                     // R4

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pd) |-> !$past(scl_s));                                 // R11

    AST_LOST_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOST) |-> !sda_pd);                                  // R8

    AST_CLEAR_ON_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_mode && $past(latch_mode) && $fell(int_pd))
            |-> ($past(state) == ST_SEND));                               // R9

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state == ST_IDLE));                                  // R10

    AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR) |-> !sda_pd);                                  // R6

endmodule

bind smb_alert_responder smb_alert_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .stop_ev    (stop_ev),
    .latch_mode (latch_mode),
    .int_pd     (int_pd),
    .sda_pd     (sda_pd),
    .state      (state_q)
);

// File: tb/sim_smb_alert_responder.sv
`timescale 1ns/1ps
module sim_smb_alert_responder;

    localparam logic [6:0] OWN = 7'h4A;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl_pd = 1'b0, m_sda_pd = 1'b0, rival_pd = 1'b0;
    logic latch_mode = 1'b1, irq_pend = 1'b0, flag_hi = 1'b0;
    logic sda_pd, int_pd;
    logic scl_bus, sda_bus;

    int n_chk = 0;
    int n_fail = 0;
    logic model_int = 1'b0;

    assign scl_bus = ~m_scl_pd;
    assign sda_bus = ~(m_sda_pd | sda_pd | rival_pd);

    always #2.5 clk = ~clk;

    smb_alert_responder u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_bus),
        .sda_in     (sda_bus),
        .latch_mode (latch_mode),
        .irq_pend   (irq_pend),
        .flag_hi    (flag_hi),
        .sda_pd     (sda_pd),
        .int_pd     (int_pd)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_cond();
        m_sda_pd = 1'b1; wait_clks(H);
        m_scl_pd = 1'b1; wait_clks(H);
    endtask

    task automatic rstart_cond();
        m_sda_pd = 1'b0; wait_clks(H);
        m_scl_pd = 1'b0; wait_clks(H);
        start_cond();
    endtask

    task automatic stop_cond();
        m_sda_pd = 1'b1; wait_clks(H);
        m_scl_pd = 1'b0; wait_clks(H);
        m_sda_pd = 1'b0; wait_clks(H);
    endtask

    // one SCL clock: low phase (check DUT drive), high phase (sample bus)
    task automatic clock_bit(input logic b, input logic exp_pd, input string req,
                             output logic seen);
        m_sda_pd = !b;
        wait_clks(6);
        chk(req, sda_pd, exp_pd);
        wait_clks(H - 6);
        m_scl_pd = 1'b0;
        wait_clks(6);
        seen = sda_bus;
        wait_clks(H - 6);
        m_scl_pd = 1'b1;
    endtask

    task automatic send_addr(input logic [7:0] ab, input logic exp_ack, input string req);
        logic seen;
        for (int i = 7; i >= 0; i--) clock_bit(ab[i], 1'b0, "R6 quiet in address", seen);
        clock_bit(1'b1, exp_ack, req, seen);
        chk(req, seen, !exp_ack);
    endtask

    // data phase after an acknowledge, with optional rival responder
    task automatic data_phase(input logic rival_en, input logic [7:0] rival_byte);
        logic [7:0] mine;
        logic lost, rlost, seen, bm, rb;
        mine = {OWN, flag_hi};
        lost = 1'b0;
        rlost = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            bm = mine[i];
            rb = (rival_en && !rlost) ? rival_byte[i] : 1'b1;
            rival_pd = !rb;
            clock_bit(1'b1, !lost && !bm, "R7 response bit drive", seen);
            chk("R8 bus bit", seen, (lost ? 1'b1 : bm) & rb);
            if (!lost && bm && !seen) lost = 1'b1;
            if (rb && !seen) rlost = 1'b1;
        end
        rival_pd = 1'b0;
        clock_bit(1'b0, 1'b0, "R9 release in host ack", seen);
        if (!lost) model_int = 1'b0;
    endtask

    task automatic check_int(input string req);
        wait_clks(4);
        chk(req, int_pd, model_int);
    endtask

    task automatic irq_pulse();
        irq_pend = 1'b1; wait_clks(3);
        irq_pend = 1'b0; wait_clks(3);
        if (latch_mode) model_int = 1'b1;
    endtask

    initial begin
        logic seen;
        wait_clks(3);
        chk("R1 sda_pd reset", sda_pd, 0);
        chk("R1 int_pd reset", int_pd, 0);
        rst_n = 1'b1;
        wait_clks(4);

        // R2 latched set
        irq_pulse();
        check_int("R2 latched set holds");

        // R2/R4 transparent mode
        latch_mode = 1'b0;
        irq_pend = 1'b1;
        model_int = 1'b1;
        check_int("R2 transparent follows high");
        start_cond();
        send_addr(8'h19, 1'b0, "R4 no ack in transparent");
        stop_cond();
        irq_pend = 1'b0;
        model_int = 1'b0;
        check_int("R2 transparent follows low");
        latch_mode = 1'b1;
        wait_clks(4);

        // R5 no alert pending
        start_cond();
        send_addr(8'h19, 1'b0, "R5 no ack without alert");
        stop_cond();

        // R6 other addresses
        irq_pulse();
        start_cond();
        send_addr(8'h18, 1'b0, "R6 no ack for 0x18");
        rstart_cond();
        send_addr(8'h90, 1'b0, "R6 no ack for 0x90");
        stop_cond();
        check_int("R6 int unchanged");

        // R8 loss at first bit against lower rival address 0x21
        flag_hi = 1'b0;
        start_cond();
        send_addr(8'h19, 1'b1, "R3 ack alert address");
        data_phase(1'b1, {7'h21, 1'b1});
        stop_cond();
        check_int("R8 int kept after early loss");

        // R8 late loss against rival 0x48
        flag_hi = 1'b1;
        start_cond();
        send_addr(8'h19, 1'b1, "R3 ack alert address");
        data_phase(1'b1, {7'h48, 1'b1});
        stop_cond();
        check_int("R8 int kept after late loss");

        // R10 repeated START right after the acknowledge
        flag_hi = 1'b0;
        start_cond();
        send_addr(8'h19, 1'b1, "R3 ack alert address");
        rstart_cond();
        chk("R10 released after restart", sda_pd, 0);
        chk("R10 int kept after restart", int_pd, 1);
        send_addr(8'h19, 1'b1, "R10 ack after restart");
        data_phase(1'b0, 8'hFF);
        stop_cond();
        check_int("R9 int cleared on win flag 0");

        // R9 repeated broadcast after win is ignored
        start_cond();
        send_addr(8'h19, 1'b0, "R9 no ack once cleared");
        stop_cond();

        // R10 STOP mid-address, then win against higher rival 0x60 with flag 1
        irq_pulse();
        start_cond();
        for (int i = 7; i >= 4; i--) clock_bit(1'b0, 1'b0, "R6 quiet in address", seen);
        stop_cond();
        chk("R10 idle after stop", sda_pd, 0);
        flag_hi = 1'b1;
        start_cond();
        send_addr(8'h19, 1'b1, "R10 ack after stop");
        data_phase(1'b1, {7'h60, 1'b1});
        stop_cond();
        check_int("R9 int cleared on win flag 1");

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule